// File: doc/BRIEF.md
# HELLO Word Sequencer for a Seven-Segment Display

This block cycles a single seven-segment digit through the letters of the word HELLO, one letter per advance pulse. It is a Moore machine: a small state register holds which letter is shown, and the segment pattern is decoded from that register alone. The two L positions are separate states, so the machine counts five positions even though only four glyphs exist.

A controller raises the advance input for one clock whenever the next letter should appear. After the O the sequence starts again at H. A synchronous reset returns the display to H. Encodings above the last state cannot be reached from the ports. If one appears anyway, the segments go dark and the next clock edge returns the machine to the first state.

Top module: `hello_seq_top`

## Requirements
- R1: When `rst` is high at a rising clock edge, `stateOut` becomes 3'b000 and `segOut` shows H after that edge, whatever `advEn` is.
- R2: When `rst` and `advEn` are both low at a rising edge, `stateOut` and `segOut` keep their values.
- R3: When `advEn` is high and `rst` is low at a rising edge, a state from 3'b000 to 3'b011 steps to the next code (value plus one).
- R4: When `advEn` is high and `rst` is low at a rising edge, state 3'b100 returns to 3'b000.
- R5: `segOut` is active high, with bit 6 = g down to bit 0 = a. It shows 7'b1110110 (H) in state 0, 7'b1111001 (E) in state 1, 7'b0111000 (L) in states 2 and 3, and 7'b0111111 (O) in state 4.
- R6: `stateOut` never leaves the range 3'b000 to 3'b100.
- R7: `segOut` depends only on `stateOut`. The new glyph appears in the same cycle as the new state, with no extra register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| advEn | input | 1 | Step to the next letter on this edge |
| stateOut | output | 3 | Current position in the word |
| segOut | output | 7 | Segment drive, active high, g..a |

## Verification
The assertions assume that `rst` is high at the first clock edge, so the state register never holds an undefined value while they are enabled. They also assume that `advEn` is a clean level sampled at the rising edge. The bench drives every input on the falling edge, and its first cycle is always a reset. Random stimulus with a fixed seed mixes advance pulses, idle gaps and occasional mid-sequence resets. Directed runs force several full wraps and a reset that coincides with an advance.

// File: rtl/hello_seq_pkg.sv
package hello_seq_pkg;
  localparam int NUM_STATES = 5;
  localparam int STATE_W = $clog2(NUM_STATES);
  localparam int SEG_W = 7;

  typedef logic [STATE_W-1:0] stateT;
  typedef logic [SEG_W-1:0] segT;

  localparam stateT FIRST_STATE = stateT'(0);
  localparam stateT LAST_STATE = stateT'(NUM_STATES - 1);

  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // load first state
    logic step;    // increment state
    logic wrap;    // step from last state back to first
  } strobeT;

  localparam segT GLYPH_H   = 7'b1110110;
  localparam segT GLYPH_E   = 7'b1111001;
  localparam segT GLYPH_L   = 7'b0111000;
  localparam segT GLYPH_O   = 7'b0111111;
  localparam segT GLYPH_OFF = 7'b0000000;

  function automatic segT glyphOf(input stateT s);
    case (s)
      stateT'(0): glyphOf = GLYPH_H;
      stateT'(1): glyphOf = GLYPH_E;
      stateT'(2): glyphOf = GLYPH_L;
      stateT'(3): glyphOf = GLYPH_L;
      stateT'(4): glyphOf = GLYPH_O;
      default:    glyphOf = GLYPH_OFF;
    endcase
  endfunction
endpackage

// File: rtl/hello_seq_ctrl.sv
module hello_seq_ctrl
  import hello_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   advEn,
  input  stateT  curState,
  output strobeT strobes
);
  logic outOfRange;
  logic atLast;

  assign outOfRange = (curState > LAST_STATE);
  assign atLast = (curState == LAST_STATE);

  always_comb begin
    strobes = '0;
    strobes.clear = rst | outOfRange;
    strobes.step = advEn & ~strobes.clear;
    strobes.wrap = strobes.step & atLast;
  end

  // R1: reset always produces a clear strobe and never a step
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |-> (strobes.clear && !strobes.step));

  // R2: no advance request, no step
  a_r2_idle_no_step: assert property (@(posedge clk) disable iff (rst)
    !advEn |-> !strobes.step);
endmodule

// File: rtl/hello_seq_dp.sv
module hello_seq_dp
  import hello_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  strobeT strobes,
  output stateT  stateQ,
  output segT    segOut
);
  stateT stateNext;

  always_comb begin
    if (strobes.clear || strobes.wrap) stateNext = FIRST_STATE;
    else if (strobes.step)             stateNext = stateQ + stateT'(1);
    else                               stateNext = stateQ;
  end

  always_ff @(posedge clk) stateQ <= stateNext;

  assign segOut = glyphOf(stateQ);

  // R1: reset lands on the first state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (stateQ == FIRST_STATE));

  // R2: hold when idle
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobes.step && !strobes.clear) |=> $stable(stateQ));

  // R3: ordinary step increments
  a_r3_increment: assert property (@(posedge clk) disable iff (rst)
    (strobes.step && !strobes.wrap) |=> (stateQ == $past(stateQ) + stateT'(1)));

  // R4: wrap returns to the first state
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    strobes.wrap |=> (stateQ == FIRST_STATE));

  // R6: state stays in range
  a_r6_in_range: assert property (@(posedge clk) disable iff (rst)
    stateQ <= LAST_STATE);

  // R7: glyph follows state in the same cycle
  a_r7_glyph_tracks: assert property (@(posedge clk) disable iff (rst)
    $stable(stateQ) |-> $stable(segOut));
endmodule

// File: rtl/hello_seq_top.sv
module hello_seq_top
  import hello_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             advEn,
  output logic [STATE_W-1:0] stateOut,
  output logic [SEG_W-1:0]   segOut
);
  strobeT strobes;
  stateT stateQ;

  hello_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .advEn(advEn),
    .curState(stateQ), .strobes(strobes)
  );

  hello_seq_dp u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .stateQ(stateQ), .segOut(segOut)
  );

  assign stateOut = stateQ;
endmodule

// File: tb/sim_hello_seq_top.sv
module sim_hello_seq_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic advEn = 1'b0;
  logic [2:0] stateOut;
  logic [6:0] segOut;
  int checks = 0;
  int failures = 0;
  int expState = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hello_seq_top u0 (.clk(clk), .rst(rst), .advEn(advEn),
                    .stateOut(stateOut), .segOut(segOut));

  function automatic logic [6:0] expGlyph(int s);
    case (s)
      0: return 7'b1110110;
      1: return 7'b1111001;
      2, 3: return 7'b0111000;
      4: return 7'b0111111;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic int nextState(int s, bit r, bit e);
    if (r) return 0;
    if (!e) return s;
    return (s == 4) ? 0 : s + 1;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at falling edge, step one clock, sample at next falling edge
  task automatic cycle(bit r, bit e);
    int prev;
    string tag;
    prev = expState;
    rst = r;
    advEn = e;
    @(posedge clk);
    @(negedge clk);
    expState = nextState(prev, r, e);
    if (r) tag = "R1";
    else if (!e) tag = "R2";
    else if (prev == 4) tag = "R4";
    else tag = "R3";
    check(tag, int'(stateOut), expState);
    check("R5/R7 glyph", int'(segOut), int'(expGlyph(expState)));
    check("R6 range", int'(stateOut <= 3'd4), 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1234;
    void'($urandom(seed));
    @(negedge clk);
    cycle(1, 0);  // R1 reset state
    check("R1 H after reset", int'(segOut), 7'b1110110);
    // R3/R4 two full wraps
    for (int i = 0; i < 10; i++) cycle(0, 1);
    // R2 hold at each position
    for (int i = 0; i < 5; i++) begin
      cycle(0, 0);
      cycle(0, 0);
      cycle(0, 1);
    end
    // R1 reset wins over advance, mid-sequence
    cycle(0, 1);
    cycle(0, 1);
    cycle(1, 1);
    check("R1 reset overrides advance", int'(stateOut), 0);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      bit r, e;
      r = ($urandom % 40) == 0;
      e = ($urandom % 3) != 0;
      cycle(r, e);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule